// File: doc/BRIEF.md
# ADC Conversion Sequencing Controller

This block is the digital sequencer that runs an on-chip 10-bit successive-approximation converter. It watches a set of register-level controls (converter enable, start, sync-mode enable, a 4-bit input select and an interrupt enable), an external sync pin and the comparator decision. From these it steps the converter through enable settling, tracking, a one-cycle sample, calibration and one trial per result bit. During this sequence it drives the track, sample, calibrate and convert strobes and the trial code for the DAC. When the sequence ends it writes the result, sets a data-valid flag and, if enabled, raises a sticky completion interrupt.

A sequence can start in two ways. In the first, a 0-to-1 change of the start control begins tracking at once. If the input select changed in the same cycle as that start change, the controller adds an extra tracking interval so that the new input can settle. In the second, with sync mode set, the start change only arms the controller. It then tracks the selected input for as long as needed, and samples on the next rising edge of the external sync pin, which passes through a two-flop synchronizer first.

States: OFF (converter disabled, all strobes low), SETTLE (wait after enable), IDLE, TRACK, XTRACK (extra tracking), ARMED (tracking, waiting for sync), SAMPLE, CAL, CONV. Transitions: any state to OFF when the enable is low. OFF to SETTLE when the enable is high. SETTLE to IDLE when its timer expires. IDLE to TRACK on a start edge in register mode, or to ARMED on a start edge in sync mode. TRACK to XTRACK when the select changed with the start, otherwise to SAMPLE. XTRACK to SAMPLE. ARMED to SAMPLE on a synchronized sync rise. SAMPLE to CAL. CAL to CONV when its timer expires. CONV to IDLE after the last bit trial.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While cfg_enable is low, trk_o, smp_o, cal_o and cnv_o are all 0 from the next cycle on, and start edges have no effect. Once the enable goes high, start edges are ignored for SETTLE_CYC+1 cycles.
- R2: With cfg_sync_mode=0, a 0-to-1 change of cfg_start seen in IDLE begins a sequence in which trk_o is high for exactly TRACK_CYC cycles.
- R3: If cfg_sel differs from its value in the previous cycle in the same cycle as the start change, trk_o stays high for TRACK_CYC+XTRACK_CYC cycles.
- R4: With cfg_sync_mode=1, a start change moves the sequencer to the armed state. In that state trk_o stays high and smp_o stays low until a rising edge of sync_pin, seen through a two-flop synchronizer, starts sampling. Sync edges seen outside the armed state are ignored.
- R5: Each sequence runs in this order: tracking, then smp_o high for 1 cycle, then cal_o high for CAL_CYC cycles, then cnv_o high for RES_BITS cycles.
- R6: The conversion tests bits from MSB to LSB. In each cnv_o cycle, dac_code equals the bits kept so far OR the bit under test, so the first trial code is the MSB alone. A tested bit is kept when cmp_above=1. The resulting code is presented on result.
- R7: data_valid goes to 0 on the clock edge that starts a sequence and goes to 1 on the edge that writes result. It stays 0 while cnv_o is high.
- R8: A start change that arrives while a sequence is in progress is ignored: no second sequence follows.
- R9: irq is set when a result is written while irq_en=1, and it stays set until irq_clr=1. A result written while irq_en=0 leaves irq unchanged. When a set and a clear happen in the same cycle, the set wins.
- R10: amux_sel is cfg_sel registered by one cycle. Codes 0 to 3 select the general inputs and codes 4 to 8 select the touch-screen voltages. Codes 9 and above are reserved and produce 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Converter enable |
| cfg_start | input | 1 | Start control; acts on a 0-to-1 change |
| cfg_sync_mode | input | 1 | 1 = arm on start, sample on sync pin |
| cfg_sel | input | SEL_W | Input select code |
| irq_en | input | 1 | Completion interrupt enable |
| irq_clr | input | 1 | Write-one-to-clear for irq |
| sync_pin | input | 1 | External asynchronous sync input |
| cmp_above | input | 1 | Comparator: input is at or above trial level |
| amux_sel | output | SEL_W | Select code driven to the analogue multiplexer |
| trk_o | output | 1 | Track strobe |
| smp_o | output | 1 | Sample strobe |
| cal_o | output | 1 | Calibration strobe |
| cnv_o | output | 1 | Bit-trial phase strobe |
| dac_code | output | RES_BITS | Trial code for the DAC |
| result | output | RES_BITS | Last conversion result |
| data_valid | output | 1 | Result-ready flag |
| irq | output | 1 | Sticky completion interrupt |

## Verification
The bench builds the controller with SETTLE_CYC=3, TRACK_CYC=2, XTRACK_CYC=4 and CAL_CYC=2, and keeps RES_BITS=10. These short phases let a plain and an extended tracking interval be measured exactly inside one short run, and they make it easy to land a second start change in the middle of calibration or the bit trials. The full 10-bit width keeps the boundary codes 0, 1023, 512 and 341 available: the comparator model makes the result equal the modelled input, so every MSB-first keep or drop decision can be checked.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_SETTLE,
        ST_IDLE,
        ST_TRACK,
        ST_XTRACK,
        ST_ARMED,
        ST_SAMPLE,
        ST_CAL,
        ST_CONV
    } seq_state_e;

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_sync_rise.sv
module adc_sync_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise = sync_q & ~prev_q;

    AST_SYNC_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R4

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
    parameter int RES_BITS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                init,
    input  logic                step,
    input  logic                cmp_above,
    output logic [RES_BITS-1:0] code,
    output logic [RES_BITS-1:0] final_code,
    output logic                last
);
    localparam logic [RES_BITS-1:0] MSB_ONLY = {1'b1, {(RES_BITS-1){1'b0}}};

    logic [RES_BITS-1:0] kept_q;
    logic [RES_BITS-1:0] ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kept_q <= '0;
            ptr_q  <= '0;
        end else if (init) begin
            kept_q <= '0;
            ptr_q  <= MSB_ONLY;
        end else if (step) begin
            if (cmp_above) begin
                kept_q <= kept_q | ptr_q;
            end
            ptr_q <= ptr_q >> 1;
        end
    end

    assign code       = kept_q | ptr_q;
    assign final_code = cmp_above ? code : kept_q;
    assign last       = ptr_q[0];

    AST_SAR_PTR_WALKS: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !init && !last && ptr_q != '0) |=> ptr_q == ($past(ptr_q) >> 1)); // R6

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RES_BITS   = 10,
    parameter int SEL_W      = 4,
    parameter int NUM_SRC    = 9,
    parameter int SETTLE_CYC = 16,
    parameter int TRACK_CYC  = 8,
    parameter int XTRACK_CYC = 24,
    parameter int CAL_CYC    = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_enable,
    input  logic                cfg_start,
    input  logic                cfg_sync_mode,
    input  logic [SEL_W-1:0]    cfg_sel,
    input  logic                irq_en,
    input  logic                irq_clr,
    input  logic                sync_pin,
    input  logic                cmp_above,
    output logic [SEL_W-1:0]    amux_sel,
    output logic                trk_o,
    output logic                smp_o,
    output logic                cal_o,
    output logic                cnv_o,
    output logic [RES_BITS-1:0] dac_code,
    output logic [RES_BITS-1:0] result,
    output logic                data_valid,
    output logic                irq
);
    localparam int MAX_DUR = int'(max2(max2(SETTLE_CYC, TRACK_CYC), max2(XTRACK_CYC, CAL_CYC)));
    localparam int CNT_W   = $clog2(MAX_DUR + 1);

    localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] TRACK_LD  = CNT_W'(TRACK_CYC - 1);
    localparam logic [CNT_W-1:0] XTRACK_LD = CNT_W'(XTRACK_CYC - 1);
    localparam logic [CNT_W-1:0] CAL_LD    = CNT_W'(CAL_CYC - 1);
    localparam logic [SEL_W-1:0] SRC_LIMIT = SEL_W'(NUM_SRC);
    localparam logic [RES_BITS-1:0] MSB_ONLY = {1'b1, {(RES_BITS-1){1'b0}}};

    seq_state_e state_q, state_d;

    logic             start_q;
    logic [SEL_W-1:0] sel_q;
    logic             xtra_q;
    logic             start_edge, sel_chg;
    logic             sync_rise;
    logic             tmr_load, tmr_exp;
    logic [CNT_W-1:0] tmr_val;
    logic             sar_init, sar_step, sar_last;
    logic [RES_BITS-1:0] sar_code, sar_final;
    logic             seq_start, conv_done;

    // ---------------- input edge detection ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            sel_q   <= '0;
        end else begin
            start_q <= cfg_start;
            sel_q   <= cfg_sel;
        end
    end

    assign start_edge = cfg_start & ~start_q;
    assign sel_chg    = (cfg_sel != sel_q);
    assign amux_sel   = (sel_q < SRC_LIMIT) ? sel_q : '0;

    // ---------------- submodules ----------------
    adc_sync_rise u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sync_pin),
        .rise     (sync_rise)
    );

    adc_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    adc_sar_core #(.RES_BITS(RES_BITS)) u_sar (
        .clk        (clk),
        .rst_n      (rst_n),
        .init       (sar_init),
        .step       (sar_step),
        .cmp_above  (cmp_above),
        .code       (sar_code),
        .final_code (sar_final),
        .last       (sar_last)
    );

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d   = state_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        sar_init  = 1'b0;
        seq_start = 1'b0;
        if (!cfg_enable) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    state_d  = ST_SETTLE;
                    tmr_load = 1'b1;
                    tmr_val  = SETTLE_LD;
                end
                ST_SETTLE: begin
                    if (tmr_exp) state_d = ST_IDLE;
                end
                ST_IDLE: begin
                    if (start_edge) begin
                        seq_start = 1'b1;
                        if (cfg_sync_mode) begin
                            state_d = ST_ARMED;
                        end else begin
                            state_d  = ST_TRACK;
                            tmr_load = 1'b1;
                            tmr_val  = TRACK_LD;
                        end
                    end
                end
                ST_TRACK: begin
                    if (tmr_exp) begin
                        if (xtra_q) begin
                            state_d  = ST_XTRACK;
                            tmr_load = 1'b1;
                            tmr_val  = XTRACK_LD;
                        end else begin
                            state_d = ST_SAMPLE;
                        end
                    end
                end
                ST_XTRACK: begin
                    if (tmr_exp) state_d = ST_SAMPLE;
                end
                ST_ARMED: begin
                    if (sync_rise) state_d = ST_SAMPLE;
                end
                ST_SAMPLE: begin
                    state_d  = ST_CAL;
                    tmr_load = 1'b1;
                    tmr_val  = CAL_LD;
                end
                ST_CAL: begin
                    if (tmr_exp) begin
                        state_d  = ST_CONV;
                        sar_init = 1'b1;
                    end
                end
                ST_CONV: begin
                    if (sar_last) state_d = ST_IDLE;
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    assign sar_step  = (state_q == ST_CONV);
    assign conv_done = cfg_enable && (state_q == ST_CONV) && sar_last;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            xtra_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (seq_start) xtra_q <= sel_chg;
        end
    end

    // ---------------- phase outputs ----------------
    always_comb begin
        trk_o    = 1'b0;
        smp_o    = 1'b0;
        cal_o    = 1'b0;
        cnv_o    = 1'b0;
        dac_code = '0;
        unique case (state_q)
            ST_TRACK, ST_XTRACK, ST_ARMED: trk_o = 1'b1;
            ST_SAMPLE:                     smp_o = 1'b1;
            ST_CAL:                        cal_o = 1'b1;
            ST_CONV: begin
                cnv_o    = 1'b1;
                dac_code = sar_code;
            end
            default: ;
        endcase
    end

    // ---------------- result, valid flag, interrupt ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result     <= '0;
            data_valid <= 1'b0;
            irq        <= 1'b0;
        end else begin
            if (seq_start) begin
                data_valid <= 1'b0;
            end else if (conv_done) begin
                data_valid <= 1'b1;
                result     <= sar_final;
            end
            if (conv_done && irq_en) begin
                irq <= 1'b1;
            end else if (irq_clr) begin
                irq <= 1'b0;
            end
        end
    end

    // ---------------- assertions ----------------
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> !(trk_o || smp_o || cal_o || cnv_o)); // R1

    AST_SYNC_GATES_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(smp_o) && $past(state_q == ST_ARMED)) |-> $past(sync_rise)); // R4

    AST_SAMPLE_BEFORE_CAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_o) |-> $past(smp_o)); // R5

    AST_CAL_BEFORE_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnv_o) |-> $past(cal_o)); // R5

    AST_FIRST_TRIAL_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnv_o) |-> dac_code == MSB_ONLY); // R6

    AST_VALID_AFTER_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_valid) |-> $past(cnv_o)); // R7

    AST_NO_VALID_IN_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_o |-> !data_valid); // R7

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(irq_en) && $past(cnv_o))); // R9

endmodule

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
    localparam int RES  = 10;
    localparam int SW   = 4;
    localparam int SETL = 3;
    localparam int TRK  = 2;
    localparam int XTRK = 4;
    localparam int CAL  = 2;

    logic clk = 1'b0;
    logic rst_n;
    logic cfg_enable, cfg_start, cfg_sync_mode, irq_en, irq_clr, sync_pin;
    logic [SW-1:0] cfg_sel;
    logic cmp_above;
    logic [SW-1:0] amux_sel;
    logic trk_o, smp_o, cal_o, cnv_o, data_valid, irq;
    logic [RES-1:0] dac_code, result;

    int vin = 0;
    assign cmp_above = (vin >= int'(dac_code));

    always #10 clk = ~clk;

    adc_seq_ctrl #(
        .RES_BITS(RES), .SEL_W(SW), .NUM_SRC(9),
        .SETTLE_CYC(SETL), .TRACK_CYC(TRK), .XTRACK_CYC(XTRK), .CAL_CYC(CAL)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_start(cfg_start),
        .cfg_sync_mode(cfg_sync_mode), .cfg_sel(cfg_sel), .irq_en(irq_en),
        .irq_clr(irq_clr), .sync_pin(sync_pin), .cmp_above(cmp_above),
        .amux_sel(amux_sel), .trk_o(trk_o), .smp_o(smp_o), .cal_o(cal_o),
        .cnv_o(cnv_o), .dac_code(dac_code), .result(result),
        .data_valid(data_valid), .irq(irq)
    );

    typedef struct {
        int value;
        int trk_len;
        bit irq_exp;
    } exp_t;

    exp_t sb_q[$];
    int checks = 0;
    int fails  = 0;
    int done_cnt = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // ---------------- monitor ----------------
    int n_trk = 0, n_smp = 0, n_cal = 0, n_cnv = 0;
    logic dv_prev = 1'b0;

    always @(negedge clk) begin
        if (!rst_n || !cfg_enable) begin
            n_trk = 0; n_smp = 0; n_cal = 0; n_cnv = 0;
        end else begin
            n_trk += int'(trk_o);
            n_smp += int'(smp_o);
            n_cal += int'(cal_o);
            n_cnv += int'(cnv_o);
            if (data_valid && !dv_prev) begin
                done_cnt++;
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R8", "unexpected result", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(int'(result) == e.value, "R6", "result code", int'(result), e.value);
                    if (e.trk_len >= 0)
                        chk(n_trk == e.trk_len, (e.trk_len == TRK) ? "R2" : "R3",
                            "track cycles", n_trk, e.trk_len);
                    chk(n_smp == 1, "R5", "sample cycles", n_smp, 1);
                    chk(n_cal == CAL, "R5", "cal cycles", n_cal, CAL);
                    chk(n_cnv == RES, "R5", "bit trial cycles", n_cnv, RES);
                    chk(irq == e.irq_exp, "R9", "irq at completion", int'(irq), int'(e.irq_exp));
                end
                n_trk = 0; n_smp = 0; n_cal = 0; n_cnv = 0;
            end
        end
        dv_prev = data_valid;
    end

    // ---------------- driver ----------------
    task automatic start_conv(input int value, input logic [SW-1:0] sel,
                              input int trk_len, input bit ien);
        exp_t e;
        @(negedge clk);
        vin       = value;
        irq_en    = ien;
        irq_clr   = 1'b1;
        cfg_sel   = sel;
        cfg_start = 1'b1;
        e.value   = value;
        e.trk_len = trk_len;
        e.irq_exp = ien;
        sb_q.push_back(e);
        @(negedge clk);
        cfg_start = 1'b0;
        irq_clr   = 1'b0;
        chk(data_valid == 1'b0, "R7", "valid cleared at start", int'(data_valid), 0);
        chk(irq == 1'b0, "R9", "irq cleared by irq_clr", int'(irq), 0);
    endtask

    task automatic wait_valid();
        int n = 0;
        while (!data_valid && n < 400) begin
            @(negedge clk);
            n++;
        end
        chk(data_valid == 1'b1, "R7", "valid set at completion", int'(data_valid), 1);
    endtask

    task automatic watch_quiet(input int cycles, input string req, input string what);
        int act = 0;
        repeat (cycles) begin
            @(negedge clk);
            act += int'(trk_o | smp_o | cal_o | cnv_o);
        end
        chk(act == 0, req, what, act, 0);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        rst_n = 1'b0; cfg_enable = 1'b0; cfg_start = 1'b0; cfg_sync_mode = 1'b0;
        irq_en = 1'b0; irq_clr = 1'b0; sync_pin = 1'b0; cfg_sel = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({trk_o, smp_o, cal_o, cnv_o} == 4'b0, "R1", "phases idle after reset",
            int'({trk_o, smp_o, cal_o, cnv_o}), 0);
        chk(data_valid == 1'b0 && irq == 1'b0, "R7", "valid and irq low after reset",
            int'({data_valid, irq}), 0);
        chk(dac_code == '0, "R6", "dac code zero after reset", int'(dac_code), 0);

        // R1: start while disabled has no effect
        cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
        watch_quiet(10, "R1", "activity while disabled");

        // R1: start during settling is ignored
        cfg_enable = 1'b1;
        @(negedge clk);
        cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
        watch_quiet(10, "R1", "start during settle");

        // R2/R3/R6/R9: register-mode conversions
        start_conv(512, 4'd0, TRK, 1'b1);
        wait_valid();
        start_conv(341, 4'd3, TRK + XTRK, 1'b0);
        wait_valid();
        start_conv(1023, 4'd3, TRK, 1'b1);
        wait_valid();
        start_conv(0, 4'd8, TRK + XTRK, 1'b1);
        wait_valid();
        @(negedge clk);
        chk(amux_sel == 4'd8, "R10", "touch source code 8", int'(amux_sel), 8);

        // R10: reserved code gives 0, general input passes
        cfg_sel = 4'd12;
        repeat (2) @(negedge clk);
        chk(amux_sel == 4'd0, "R10", "reserved code 12", int'(amux_sel), 0);
        cfg_sel = 4'd5;
        repeat (2) @(negedge clk);
        chk(amux_sel == 4'd5, "R10", "code 5", int'(amux_sel), 5);

        // R8: second start edge while busy is ignored
        start_conv(700, 4'd5, TRK, 1'b0);
        repeat (6) @(negedge clk);
        cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
        wait_valid();
        begin
            int act = 0;
            int dv_low = 0;
            repeat (30) begin
                @(negedge clk);
                act += int'(trk_o);
                dv_low += int'(!data_valid);
            end
            chk(act == 0 && dv_low == 0, "R8", "no second sequence", act + dv_low, 0);
        end
        chk(sb_q.size() == 0, "R8", "scoreboard drained", sb_q.size(), 0);

        // R4: sync edge outside armed state is ignored
        cfg_sync_mode = 1'b1;
        sync_pin = 1'b1;
        repeat (3) @(negedge clk);
        sync_pin = 1'b0;
        watch_quiet(10, "R4", "sync edge while idle");

        // R4: armed tracking waits for sync
        start_conv(100, 4'd5, -1, 1'b1);
        begin
            int trk_n = 0;
            int smp_n = 0;
            repeat (20) begin
                @(negedge clk);
                trk_n += int'(trk_o);
                smp_n += int'(smp_o);
            end
            chk(trk_n == 20, "R4", "tracking while armed", trk_n, 20);
            chk(smp_n == 0, "R4", "no sample before sync", smp_n, 0);
        end
        sync_pin = 1'b1;
        wait_valid();
        sync_pin = 1'b0;
        @(negedge clk);
        chk(done_cnt == 6, "R7", "completed sequences", done_cnt, 6);

        // R1: dropping enable mid-sequence silences all phases
        cfg_sync_mode = 1'b0;
        @(negedge clk);
        cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
        @(negedge clk);
        chk(trk_o == 1'b1, "R2", "tracking in progress", int'(trk_o), 1);
        cfg_enable = 1'b0;
        @(negedge clk);
        chk({trk_o, smp_o, cal_o, cnv_o} == 4'b0, "R1", "phases off after disable",
            int'({trk_o, smp_o, cal_o, cnv_o}), 0);
        watch_quiet(10, "R1", "held off while disabled");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule